// File: doc/BRIEF.md
# Dual-Target Pin Event Interrupt Unit

This block watches a set of general-purpose input pins and turns selected pin activity into interrupt requests for two processors. Every pin is captured in a register stage on the module clock. For each channel, software selects any mix of four detection conditions: rising edge, falling edge, high level and low level. A condition that holds produces a per-channel event for that cycle.

Events go to two identical target units, one per processor. Each target has its own raw status register, its own enable register and its own interrupt line. An event is latched into both raw status registers whatever the enables hold. An enable decides only whether a latched bit drives that target's interrupt line. Software clears raw status by writing ones. Enables change through separate set and clear addresses, so one processor can change its own bits without a read-modify-write. A simple single-cycle register bus holds the configuration. Reads are combinational from the address.

Top module: `evt_irq_dual`

## Requirements
- R1: After a synchronous active-low reset, all detection selects, both raw status registers and both enable registers are zero, and both interrupt lines are low.
- R2: With the rising select of a channel set, a 0-to-1 change of its pin sampled on edge k sets that channel's raw bit in both targets on edge k+1.
- R3: With the falling select set, a 1-to-0 change sampled on edge k sets the raw bit in both targets on edge k+1.
- R4: With the high select set, a raw bit is set on every edge that follows a cycle in which the captured pin is 1. While the level lasts, a write-one clear is undone on the next edge.
- R5: With the low select set, the same holds for a captured pin level of 0.
- R6: When several selects of one channel are set, their conditions are ORed. Rising and falling together detect both edges.
- R7: Raw status latches events whether or not the channel is enabled. An interrupt line stays low while its target's enable is zero.
- R8: Writing the raw address of a target clears exactly the bits written as 1 and leaves the other bits alone. An event in the same cycle wins over the clear.
- R9: Writing the set address ORs wdata into the enable, and writing the clear address removes the wdata bits. Reading either address returns the enable.
- R10: Reading the masked address of a target returns raw AND enable of that target.
- R11: Each interrupt line is high exactly when its target's raw AND enable is nonzero. The two targets' enables and clears do not affect each other.
- R12: Address 0 returns the captured pin levels, which follow the pins one edge later.
- R13: Address map (4-bit address): 0 levels (read only), 1 rising select, 2 falling select, 3 high select, 4 low select. Target t uses base 8+4t, with offset 0 raw (write-one clear), 1 masked (read only), 2 enable set, 3 enable clear. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | synchronous active-low reset |
| pin_i | input | NCH | general-purpose input pins |
| bus_we | input | 1 | write strobe, one write per cycle |
| bus_addr | input | 4 | register address |
| bus_wdata | input | NCH | write data |
| bus_rdata | output | NCH | read data, combinational from bus_addr |
| irq_o | output | 2 | interrupt line per target |

## Verification
Each pin change that is sampled on edge k shows on the level readback after edge k. The events it causes show in raw status, masked status and the interrupt lines after edge k+1. A bus write takes effect on the edge that samples it, and a readback reflects it right after that edge. The bench model applies these same latencies one posedge at a time. The bench compares both interrupt lines and the read data on every falling edge, where all registered results have settled.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned EVT_AW = 4;
  localparam int unsigned NTGT   = 2;

  localparam logic [EVT_AW-1:0] A_LEVEL = 4'h0;
  localparam logic [EVT_AW-1:0] A_RISE  = 4'h1;
  localparam logic [EVT_AW-1:0] A_FALL  = 4'h2;
  localparam logic [EVT_AW-1:0] A_HIGH  = 4'h3;
  localparam logic [EVT_AW-1:0] A_LOW   = 4'h4;

  // target t occupies 8 + 4*t .. 8 + 4*t + 3
  typedef enum logic [1:0] {
    OFF_RAW = 2'd0,
    OFF_MSK = 2'd1,
    OFF_SET = 2'd2,
    OFF_CLR = 2'd3
  } tgt_off_e;
endpackage

// File: rtl/evt_detect.sv
module evt_detect #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] rise_en,
  input  logic [NCH-1:0] fall_en,
  input  logic [NCH-1:0] hi_en,
  input  logic [NCH-1:0] lo_en,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] ev_o
);
  logic [NCH-1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= pin_i;
      prev_q <= cur_q;
    end
  end

  always_comb begin
    ev_o = (rise_en & cur_q & ~prev_q)
         | (fall_en & ~cur_q & prev_q)
         | (hi_en & cur_q)
         | (lo_en & ~cur_q);
  end

  assign lvl_o = cur_q;

  // R2/R3: a pin that holds still with no level select raises no event
  a_r2_quiet_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q == prev_q) && (hi_en == '0) && (lo_en == '0)) |-> (ev_o == '0));
endmodule

// File: rtl/evt_target.sv
module evt_target #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_i,
  input  logic           w1c_we,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  logic [NCH-1:0] raw_q, en_q, clr_mask;

  assign clr_mask = w1c_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | ev_i;
      if (set_we)      en_q <= en_q | wdata;
      else if (clr_we) en_q <= en_q & ~wdata;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |(raw_q & en_q);

  // R7: every event is latched on the next edge
  a_r7_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(ev_i)) == $past(ev_i)));
  // R8: a raw bit only rises when an event was present
  a_r8_no_spurious_raw: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev_i)) == '0));
  // R9: set write ORs in, clear write removes
  a_r9_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
  a_r9_clr_applies: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/evt_irq_dual.sv
module evt_irq_dual #(
  parameter int unsigned NCH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             pin_i,
  input  logic                       bus_we,
  input  logic [evt_pkg::EVT_AW-1:0] bus_addr,
  input  logic [NCH-1:0]             bus_wdata,
  output logic [NCH-1:0]             bus_rdata,
  output logic [evt_pkg::NTGT-1:0]   irq_o
);
  import evt_pkg::*;

  logic [NCH-1:0] rise_q, fall_q, hi_q, lo_q;
  logic [NCH-1:0] lvl, ev;
  logic [NCH-1:0] raw [NTGT];
  logic [NCH-1:0] en  [NTGT];
  logic [NTGT-1:0] w1c_we, set_we, clr_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_RISE:  rise_q <= bus_wdata;
        A_FALL:  fall_q <= bus_wdata;
        A_HIGH:  hi_q   <= bus_wdata;
        A_LOW:   lo_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  evt_detect #(.NCH(NCH)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .rise_en (rise_q),
    .fall_en (fall_q),
    .hi_en   (hi_q),
    .lo_en   (lo_q),
    .lvl_o   (lvl),
    .ev_o    (ev)
  );

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    localparam logic [EVT_AW-1:0] BASE = EVT_AW'(8 + 4 * t);
    logic hit;
    assign hit       = bus_we && (bus_addr[EVT_AW-1:2] == BASE[EVT_AW-1:2]);
    assign w1c_we[t] = hit && (tgt_off_e'(bus_addr[1:0]) == OFF_RAW);
    assign set_we[t] = hit && (tgt_off_e'(bus_addr[1:0]) == OFF_SET);
    assign clr_we[t] = hit && (tgt_off_e'(bus_addr[1:0]) == OFF_CLR);

    evt_target #(.NCH(NCH)) u_tgt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (ev),
      .w1c_we (w1c_we[t]),
      .set_we (set_we[t]),
      .clr_we (clr_we[t]),
      .wdata  (bus_wdata),
      .raw_o  (raw[t]),
      .en_o   (en[t]),
      .irq_o  (irq_o[t])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LEVEL: bus_rdata = lvl;
      A_RISE:  bus_rdata = rise_q;
      A_FALL:  bus_rdata = fall_q;
      A_HIGH:  bus_rdata = hi_q;
      A_LOW:   bus_rdata = lo_q;
      default: begin
        for (int t = 0; t < NTGT; t++) begin
          if (bus_addr[EVT_AW-1:2] == 2'(2 + t)) begin
            case (tgt_off_e'(bus_addr[1:0]))
              OFF_RAW: bus_rdata = raw[t];
              OFF_MSK: bus_rdata = raw[t] & en[t];
              default: bus_rdata = en[t];
            endcase
          end
        end
      end
    endcase
  end

  // R11: a target's line stays low while its enable is empty
  a_r11_line_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] == '0) |-> !irq_o[0]);
  // R11: clearing target 0 status leaves target 1 status intact
  a_r11_targets_independent: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_we[0] |=> ((raw[1] & $past(raw[1])) == $past(raw[1])));
  // R13: at most one target decodes a write
  a_r13_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w1c_we, set_we, clr_we}));
endmodule

// File: tb/evt_irq_dual_bench.sv
`timescale 1ns/1ps
module evt_irq_dual_bench;
  localparam int NCH = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [NCH-1:0] bus_wdata = '0;
  logic [NCH-1:0] bus_rdata;
  logic [1:0] irq_o;

  always #2.5 clk = ~clk;

  evt_irq_dual #(.NCH(NCH)) u_evt_irq_dual (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  int vectors = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [NCH-1:0] m_cur, m_prev, m_rise, m_fall, m_hi, m_lo;
  logic [NCH-1:0] m_raw [2];
  logic [NCH-1:0] m_en  [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = '0; m_prev = '0; m_rise = '0; m_fall = '0; m_hi = '0; m_lo = '0;
      for (int t = 0; t < 2; t++) begin m_raw[t] = '0; m_en[t] = '0; end
    end else begin
      logic [NCH-1:0] ev;
      ev = (m_rise & m_cur & ~m_prev) | (m_fall & ~m_cur & m_prev)
         | (m_hi & m_cur) | (m_lo & ~m_cur);
      for (int t = 0; t < 2; t++) begin
        if (bus_we && bus_addr == 4'(8 + 4 * t)) m_raw[t] = m_raw[t] & ~bus_wdata;
        m_raw[t] = m_raw[t] | ev;
        if (bus_we && bus_addr == 4'(10 + 4 * t)) m_en[t] = m_en[t] | bus_wdata;
        if (bus_we && bus_addr == 4'(11 + 4 * t)) m_en[t] = m_en[t] & ~bus_wdata;
      end
      if (bus_we) begin
        if (bus_addr == 4'h1) m_rise = bus_wdata;
        if (bus_addr == 4'h2) m_fall = bus_wdata;
        if (bus_addr == 4'h3) m_hi = bus_wdata;
        if (bus_addr == 4'h4) m_lo = bus_wdata;
      end
      m_prev = m_cur;
      m_cur = pin_i;
    end
  end

  function automatic logic [NCH-1:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return m_cur;
      4'h1: return m_rise;
      4'h2: return m_fall;
      4'h3: return m_hi;
      4'h4: return m_lo;
      4'h8: return m_raw[0];
      4'h9: return m_raw[0] & m_en[0];
      4'hA, 4'hB: return m_en[0];
      4'hC: return m_raw[1];
      4'hD: return m_raw[1] & m_en[1];
      4'hE, 4'hF: return m_en[1];
      default: return '0;
    endcase
  endfunction

  // every-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n || cur_req == "R1") begin
      logic [1:0] exp_irq;
      logic [NCH-1:0] exp_rd;
      exp_irq = rst_n ? {|(m_raw[1] & m_en[1]), |(m_raw[0] & m_en[0])} : 2'b00;
      exp_rd  = rst_n ? m_read(bus_addr) : bus_rdata;
      vectors++;
      if (irq_o !== exp_irq) begin
        errors++;
        $display("FAIL %s irq actual=%b expected=%b t=%0t", cur_req, irq_o, exp_irq, $time);
      end
      vectors++;
      if (bus_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, bus_addr,
                 bus_rdata, exp_rd, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #0.5; end
  endtask
  task automatic wr(input logic [3:0] a, input logic [NCH-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    idle(1);
    bus_we = 1'b0;
  endtask
  task automatic look(input logic [3:0] a, input int n);
    bus_addr = a; idle(n);
  endtask
  task automatic pins(input logic [NCH-1:0] v, input logic [3:0] a);
    pin_i = v; look(a, 3);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(3);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a); #0.1;
      vectors++;
      if (bus_rdata !== '0 || irq_o !== 2'b00) begin
        errors++;
        $display("FAIL R1 reset addr %0d actual=%h/%b expected=0/00", a, bus_rdata, irq_o);
      end
    end
    rst_n = 1'b1;
    look(4'h8, 2);
    cur_req = "R12"; pins(32'hA5A5_0F0F, 4'h0); pins(32'h0000_FFFF, 4'h0);
    pins(32'h0, 4'h0);
    cur_req = "R2"; wr(4'h1, 32'h0000_000F);
    pins(32'h0000_0005, 4'h8); pins(32'h0000_0000, 4'hC);
    cur_req = "R7"; look(4'h9, 2);
    cur_req = "R9"; wr(4'hA, 32'h0000_0003); look(4'hA, 2); wr(4'hB, 32'h1); look(4'hB, 2);
    cur_req = "R10"; look(4'h9, 2);
    cur_req = "R8"; wr(4'h8, 32'h0000_0004); look(4'h8, 2);
    wr(4'h8, 32'hFFFF_FFFF); look(4'h8, 2);
    pin_i = 32'h2; bus_we = 1'b0; idle(1); wr(4'h8, 32'h2); look(4'h8, 2);
    cur_req = "R3"; wr(4'h1, 32'h0); wr(4'h2, 32'h0000_00F0);
    pins(32'h0000_00F2, 4'h8); pins(32'h0000_0012, 4'h8); wr(4'h8, 32'hFFFF_FFFF);
    cur_req = "R4"; wr(4'h2, 32'h0); wr(4'h3, 32'h0000_0100);
    pins(32'h0000_0100, 4'h8); wr(4'h8, 32'h0000_0100); look(4'h8, 2);
    pins(32'h0, 4'h8); wr(4'h8, 32'h0000_0100); look(4'h8, 2);
    cur_req = "R5"; wr(4'h3, 32'h0); wr(4'h4, 32'h0000_0200);
    look(4'hC, 2); wr(4'hC, 32'hFFFF_FFFF); look(4'hC, 2);
    pins(32'h0000_0200, 4'hC); wr(4'hC, 32'hFFFF_FFFF); look(4'hC, 2);
    cur_req = "R6"; wr(4'h4, 32'h0); wr(4'h1, 32'h0000_1000); wr(4'h2, 32'h0000_1000);
    wr(4'h8, 32'hFFFF_FFFF);
    pins(32'h0000_1000, 4'h8); wr(4'h8, 32'hFFFF_FFFF); pins(32'h0, 4'h8);
    cur_req = "R11"; wr(4'hE, 32'h0000_1000); look(4'hD, 2);
    wr(4'h8, 32'hFFFF_FFFF); look(4'hC, 2); wr(4'hF, 32'hFFFF_FFFF); look(4'hD, 2);
    cur_req = "R13"; for (int a = 5; a < 8; a++) begin wr(4'(a), 32'hFFFF_FFFF); look(4'(a), 1); end
    // mixed stress across all registers
    cur_req = "R11";
    wr(4'h1, 32'h1234_5678); wr(4'h2, 32'h8765_4321); wr(4'h3, 32'h0F00_0000);
    wr(4'h4, 32'h00F0_0000); wr(4'hA, 32'hFFFF_0000); wr(4'hE, 32'h0000_FFFF);
    begin
      logic [NCH-1:0] lf = 32'hACE1_2468;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        pin_i = lf;
        if (i % 7 == 3) wr(4'(8 + 4 * (i % 2)), lf ^ 32'h5A5A_5A5A);
        else if (i % 11 == 5) wr(4'(10 + (i % 4)), lf);
        else look(4'(i % 16), 1);
      end
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule